// File: doc/BRIEF.md
# Chainable Serial Command Port for a Multi-Channel Register Bank

This block is the slave end of a three-wire serial link, with a select line, that loads and reads back the settings of a multi-channel converter. A host lowers the active-low select, clocks in 24-bit commands MSB first, and raises the select to commit them. Each command carries a read flag, a register kind and a channel number. Writes update the per-channel data word, the per-channel fine gain, the per-channel offset, or a single control register. The register contents leave the block as flat vectors for the converter logic.

The serial output has two uses. Any bit pushed past the 24-bit shift register comes out on the serial output, so that several devices wired output-to-input share one select and one serial clock and each takes 24 clocks. When a read request was committed in one frame, the 24-bit reply is preloaded into the shift register at the start of the next frame and shifts out during that frame's first 24 clocks. The serial lines are oversampled by the system clock, which must run several times faster than the serial clock.

Top module: `serial_regbank_port`

## Requirements
- R1: After synchronous reset, every data, gain and offset output is zero, `sdo` is 0 and `sdo_oe` is 1.
- R2: Bits are taken from `sdin` only on falling edges of `sclk` while `sync_n` is low. Serial clocks while `sync_n` is high do not affect the shift register or the next reply.
- R3: The frame layout, MSB first, is: bit 23 read flag, bit 22 reserved, bits 21..19 kind, bits 18..16 channel, bits 15..0 payload. A write with kind 010 sets the channel data word to the payload. Kind 100 sets the fine gain to payload[5:0]. Kind 101 sets the offset to payload[7:0]. Kind 000 with channel 001 sets the output-disable bit to payload[0]. Kind 000 with channel 000 is a no-operation.
- R4: A rising edge of `sync_n` commits the last 24 bits received when at least 24 falling clocks came in that frame. A frame with fewer than 24 clocks changes nothing.
- R5: `sdo` changes only on rising `sclk` edges. Each bit shifted past the 24-bit register appears there 24 clocks after it entered, so a chain of n devices driven with 24n clocks delivers the k-th last frame to the k-th device.
- R6: A frame with bit 23 set changes no register. During the next frame, the first 24 `sdo` bits are {2'b00, kind, channel, value}, where value is the addressed register zero-extended to 16 bits. An unsupported kind or a channel that does not exist reads as 0.
- R7: A reply is delivered once. In a frame not preceded by a read request, the first 24 `sdo` bits are zero.
- R8: While the output-disable bit is 1, `sdo` stays 0 and `sdo_oe` is 0.
- R9: A write to a channel number of 4 or more, with an unlisted kind, or with bit 22 set changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock |
| sync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data in, sampled on falling `sclk` |
| sdo | output | 1 | Chain pass-through and readback output |
| sdo_oe | output | 1 | High while the serial output is enabled |
| data_out | output | NCH*16 | Per-channel data words, channel 0 in the low bits |
| gain_out | output | NCH*6 | Per-channel fine gain |
| offset_out | output | NCH*8 | Per-channel offset |

## Verification
Three instances are wired as a chain and driven with 24, 48 and 72 clocks per frame. The bench compares every `sdo` bit of every device against a stream model, so a design with the reply shifted by one position, or with the pass-through taken on the wrong edge, fails on the first chained frame. Frames with extra leading bits and frames shorter than 24 clocks target a design that keeps the first 24 bits or commits partial words. Stray serial clocks with the select high sit between a read request and its reply, and a corrupted reply exposes a shifter that ignores the select. A second frame after a reply must return zeros, which catches a reply that is never cleared. Disabling the output on the head device must silence both its own pin and everything downstream.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int FRAME_W   = 24;
    localparam int PAYLOAD_W = 16;
    localparam int CNT_W     = $clog2(FRAME_W + 1);

    typedef enum logic [2:0] {
        KIND_CTRL  = 3'b000,
        KIND_DATA  = 3'b010,
        KIND_FGAIN = 3'b100,
        KIND_OFFS  = 3'b101
    } kind_e;

    localparam logic [2:0] CTRL_FUNC = 3'b001;

    typedef struct packed {
        logic                 rd;
        logic                 rsv;
        logic [2:0]           kind;
        logic [2:0]           chan;
        logic [PAYLOAD_W-1:0] payload;
    } frame_t;

    function automatic logic chan_ok(logic [2:0] chan, int nch);
        return int'(chan) < nch;
    endfunction

    function automatic logic [FRAME_W-1:0] reply_word(logic [2:0] kind, logic [2:0] chan,
                                                      logic [PAYLOAD_W-1:0] val);
        return {2'b00, kind, chan, val};
    endfunction

endpackage

// File: rtl/srp_shifter.sv
module srp_shifter
    import srp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sclk,
    input  logic               sync_n,
    input  logic               sdin,
    input  logic               quiet,
    input  logic [FRAME_W-1:0] load_word,
    output logic               load_take,
    output logic               frame_done,
    output logic [FRAME_W-1:0] frame_word,
    output logic               sdo_q
);

    logic sclk_s, sclk_d, sync_s, sync_d, sdin_s;
    logic [FRAME_W-1:0] sr;
    logic [CNT_W-1:0]   cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_s <= 1'b0;
            sclk_d <= 1'b0;
            sync_s <= 1'b1;
            sync_d <= 1'b1;
            sdin_s <= 1'b0;
        end else begin
            sclk_s <= sclk;
            sclk_d <= sclk_s;
            sync_s <= sync_n;
            sync_d <= sync_s;
            sdin_s <= sdin;
        end
    end

    logic sclk_rise, sclk_fall, sync_fall, sync_rise;
    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign sync_fall = ~sync_s & sync_d;
    assign sync_rise = sync_s & ~sync_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr    <= '0;
            cnt   <= '0;
            sdo_q <= 1'b0;
        end else begin
            if (sync_fall) begin
                sr  <= load_word;
                cnt <= '0;
            end else if (!sync_s && sclk_fall) begin
                sr <= {sr[FRAME_W-2:0], sdin_s};
                if (cnt != CNT_W'(FRAME_W))
                    cnt <= cnt + 1'b1;
            end
            if (quiet)
                sdo_q <= 1'b0;
            else if (!sync_s && sclk_rise)
                sdo_q <= sr[FRAME_W-1];
        end
    end

    assign load_take  = sync_fall;
    assign frame_done = sync_rise && (cnt == CNT_W'(FRAME_W));
    assign frame_word = sr;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        sync_s |=> $stable(sr)); // R2
    AST_SDO_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (!sclk_rise && !quiet) |=> $stable(sdo_q)); // R5
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(FRAME_W)); // R4

endmodule

// File: rtl/srp_regfile.sv
module srp_regfile
    import srp_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int GAIN_W = 6,
    parameter int OFFS_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    frame_done,
    input  logic [FRAME_W-1:0]      frame_word,
    input  logic                    load_take,
    output logic [FRAME_W-1:0]      load_word,
    output logic [NCH*PAYLOAD_W-1:0] data_flat,
    output logic [NCH*GAIN_W-1:0]   gain_flat,
    output logic [NCH*OFFS_W-1:0]   offs_flat,
    output logic                    out_dis
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    logic [PAYLOAD_W-1:0] dreg [NCH];
    logic [GAIN_W-1:0]    greg [NCH];
    logic [OFFS_W-1:0]    oreg [NCH];
    logic                 pend;
    logic [2:0]           rd_kind, rd_chan;
    frame_t               f;

    assign f = frame_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                dreg[i] <= '0;
                greg[i] <= '0;
                oreg[i] <= '0;
            end
            out_dis <= 1'b0;
            pend    <= 1'b0;
            rd_kind <= '0;
            rd_chan <= '0;
        end else begin
            if (load_take)
                pend <= 1'b0;
            if (frame_done) begin
                if (f.rd) begin
                    pend    <= 1'b1;
                    rd_kind <= f.kind;
                    rd_chan <= f.chan;
                end else if (!f.rsv) begin
                    case (kind_e'(f.kind))
                        KIND_DATA:  if (chan_ok(f.chan, NCH)) dreg[f.chan[CH_W-1:0]] <= f.payload;
                        KIND_FGAIN: if (chan_ok(f.chan, NCH)) greg[f.chan[CH_W-1:0]] <= f.payload[GAIN_W-1:0];
                        KIND_OFFS:  if (chan_ok(f.chan, NCH)) oreg[f.chan[CH_W-1:0]] <= f.payload[OFFS_W-1:0];
                        KIND_CTRL:  if (f.chan == CTRL_FUNC) out_dis <= f.payload[0];
                        default: ;
                    endcase
                end
            end
        end
    end

    logic [PAYLOAD_W-1:0] rd_val;
    always_comb begin
        rd_val = '0;
        case (kind_e'(rd_kind))
            KIND_DATA:  if (chan_ok(rd_chan, NCH)) rd_val = dreg[rd_chan[CH_W-1:0]];
            KIND_FGAIN: if (chan_ok(rd_chan, NCH))
                            rd_val = {{(PAYLOAD_W-GAIN_W){1'b0}}, greg[rd_chan[CH_W-1:0]]};
            KIND_OFFS:  if (chan_ok(rd_chan, NCH))
                            rd_val = {{(PAYLOAD_W-OFFS_W){1'b0}}, oreg[rd_chan[CH_W-1:0]]};
            KIND_CTRL:  if (rd_chan == CTRL_FUNC) rd_val = {{(PAYLOAD_W-1){1'b0}}, out_dis};
            default: ;
        endcase
    end

    assign load_word = pend ? reply_word(rd_kind, rd_chan, rd_val) : '0;

    for (genvar i = 0; i < NCH; i++) begin : g_flat
        assign data_flat[i*PAYLOAD_W +: PAYLOAD_W] = dreg[i];
        assign gain_flat[i*GAIN_W +: GAIN_W]       = greg[i];
        assign offs_flat[i*OFFS_W +: OFFS_W]       = oreg[i];
    end

    AST_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (frame_done && f.rd) |=> ($stable(data_flat) && $stable(gain_flat)
                                  && $stable(offs_flat) && $stable(out_dis))); // R6
    AST_REPLY_ONCE: assert property (@(posedge clk) disable iff (rst)
        load_take |=> !pend); // R7
    AST_COMMIT_ONLY: assert property (@(posedge clk) disable iff (rst)
        !frame_done |=> ($stable(data_flat) && $stable(gain_flat) && $stable(offs_flat))); // R4

endmodule

// File: rtl/serial_regbank_port.sv
module serial_regbank_port
    import srp_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int GAIN_W = 6,
    parameter int OFFS_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sclk,
    input  logic                     sync_n,
    input  logic                     sdin,
    output logic                     sdo,
    output logic                     sdo_oe,
    output logic [NCH*PAYLOAD_W-1:0] data_out,
    output logic [NCH*GAIN_W-1:0]    gain_out,
    output logic [NCH*OFFS_W-1:0]    offset_out
);

    logic               load_take, frame_done, out_dis;
    logic [FRAME_W-1:0] load_word, frame_word;

    srp_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .sclk       (sclk),
        .sync_n     (sync_n),
        .sdin       (sdin),
        .quiet      (out_dis),
        .load_word  (load_word),
        .load_take  (load_take),
        .frame_done (frame_done),
        .frame_word (frame_word),
        .sdo_q      (sdo)
    );

    srp_regfile #(.NCH(NCH), .GAIN_W(GAIN_W), .OFFS_W(OFFS_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .frame_done (frame_done),
        .frame_word (frame_word),
        .load_take  (load_take),
        .load_word  (load_word),
        .data_flat  (data_out),
        .gain_flat  (gain_out),
        .offs_flat  (offset_out),
        .out_dis    (out_dis)
    );

    assign sdo_oe = ~out_dis;

    AST_QUIET_OUT: assert property (@(posedge clk) disable iff (rst)
        out_dis |=> !sdo); // R8

endmodule

// File: tb/serial_regbank_port_test.sv
`timescale 1ns/1ps
module serial_regbank_port_test;

    localparam int NCH = 4, GW = 6, OW = 8, MAXB = 100;

    logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, sync_n = 1'b1, sdin = 1'b0;
    always #2.5 clk = ~clk;

    logic sdo_w [3];
    logic oe_w  [3];
    logic [NCH*16-1:0] dfl [3];
    logic [NCH*GW-1:0] gfl [3];
    logic [NCH*OW-1:0] ofl [3];

    serial_regbank_port uut (.clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
        .sdo(sdo_w[0]), .sdo_oe(oe_w[0]), .data_out(dfl[0]), .gain_out(gfl[0]), .offset_out(ofl[0]));
    serial_regbank_port u2 (.clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .sdin(sdo_w[0]),
        .sdo(sdo_w[1]), .sdo_oe(oe_w[1]), .data_out(dfl[1]), .gain_out(gfl[1]), .offset_out(ofl[1]));
    serial_regbank_port u3 (.clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .sdin(sdo_w[1]),
        .sdo(sdo_w[2]), .sdo_oe(oe_w[2]), .data_out(dfl[2]), .gain_out(gfl[2]), .offset_out(ofl[2]));

    logic [15:0]   m_data [3][NCH];
    logic [GW-1:0] m_gain [3][NCH];
    logic [OW-1:0] m_offs [3][NCH];
    logic          m_dis  [3];
    logic          m_pend [3];
    logic [23:0]   m_pw   [3];
    logic [MAXB-1:0] exp_o [3];
    logic [MAXB-1:0] act_o [3];
    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, a, e);
        end
    endtask

    function automatic logic [23:0] mk(bit rd, logic [2:0] kind, logic [2:0] ch, logic [15:0] pl);
        return {rd, 1'b0, kind, ch, pl};
    endfunction

    // frame for device k sits in w[k]; the head device (uut) receives the last one sent
    function automatic logic [MAXB-1:0] pack(int n, logic [23:0] w0, logic [23:0] w1, logic [23:0] w2);
        logic [MAXB-1:0] b = '0;
        logic [23:0] w [3];
        w[0] = w0; w[1] = w1; w[2] = w2;
        for (int s = 0; s < n; s++)
            for (int j = 0; j < 24; j++)
                b[s*24 + j] = w[n-1-s][23-j];
        return b;
    endfunction

    task automatic model_latch(int d, logic [23:0] w);
        int ch = int'(w[18:16]);
        logic [15:0] v = '0;
        if (w[23]) begin
            case (w[21:19])
                3'b010: if (ch < NCH) v = m_data[d][ch];
                3'b100: if (ch < NCH) v = 16'(m_gain[d][ch]);
                3'b101: if (ch < NCH) v = 16'(m_offs[d][ch]);
                3'b000: if (ch == 1) v = 16'(m_dis[d]);
                default: ;
            endcase
            m_pend[d] = 1'b1;
            m_pw[d]   = {2'b00, w[21:16], v};
        end else if (!w[22]) begin
            case (w[21:19])
                3'b010: if (ch < NCH) m_data[d][ch] = w[15:0];
                3'b100: if (ch < NCH) m_gain[d][ch] = w[GW-1:0];
                3'b101: if (ch < NCH) m_offs[d][ch] = w[OW-1:0];
                3'b000: if (ch == 1) m_dis[d] = w[0];
                default: ;
            endcase
        end
    endtask

    task automatic cmp_regs(input string tag);
        for (int d = 0; d < 3; d++) begin
            logic [NCH*16-1:0] ed;
            logic [NCH*GW-1:0] eg;
            logic [NCH*OW-1:0] eo;
            for (int c = 0; c < NCH; c++) begin
                ed[c*16 +: 16] = m_data[d][c];
                eg[c*GW +: GW] = m_gain[d][c];
                eo[c*OW +: OW] = m_offs[d][c];
            end
            chk(dfl[d] == ed && gfl[d] == eg && ofl[d] == eo && oe_w[d] == !m_dis[d], tag,
                {dfl[d][47:0], gfl[d][15:0]}, {ed[47:0], eg[15:0]});
        end
    endtask

    task automatic run_frame(input int nb, input logic [MAXB-1:0] bits, input string tag);
        logic [MAXB-1:0] instr [3];
        for (int d = 0; d < 3; d++) begin
            logic [23:0] init = m_pend[d] ? m_pw[d] : 24'h0;
            instr[d] = (d == 0) ? bits : exp_o[d-1];
            exp_o[d] = '0;
            for (int i = 0; i < nb; i++)
                exp_o[d][i] = m_dis[d] ? 1'b0 : ((i < 24) ? init[23-i] : instr[d][i-24]);
            m_pend[d] = 1'b0;
            act_o[d] = '0;
        end
        @(negedge clk) sync_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            sclk = 1'b1;
            repeat (6) @(negedge clk);
            for (int d = 0; d < 3; d++) act_o[d][i] = sdo_w[d];
            sdin = bits[i];
            repeat (2) @(negedge clk);
            sclk = 1'b0;
            repeat (8) @(negedge clk);
        end
        sync_n = 1'b1;
        repeat (6) @(negedge clk);
        for (int d = 0; d < 3; d++)
            chk(act_o[d] == exp_o[d], $sformatf("R5 sdo stream dev%0d %s", d, tag),
                act_o[d][63:0], exp_o[d][63:0]);
        if (nb >= 24)
            for (int d = 0; d < 3; d++) begin
                logic [23:0] w;
                for (int j = 0; j < 24; j++) w[23-j] = instr[d][nb-24+j];
                model_latch(d, w);
            end
        cmp_regs($sformatf("R3 regs %s", tag));
    endtask

    function automatic logic [23:0] head_reply();
        logic [23:0] g;
        for (int j = 0; j < 24; j++) g[23-j] = act_o[0][j];
        return g;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R5 watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] snap;
        void'($urandom(32'd7305));
        for (int d = 0; d < 3; d++) begin
            m_dis[d] = 0; m_pend[d] = 0; m_pw[d] = 0; exp_o[d] = 0;
            for (int c = 0; c < NCH; c++) begin
                m_data[d][c] = 0; m_gain[d][c] = 0; m_offs[d][c] = 0;
            end
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk(dfl[0] == 0 && gfl[0] == 0 && ofl[0] == 0, "R1 regs zero", dfl[0], 0);
        chk(sdo_w[0] == 0 && oe_w[0] == 1, "R1 sdo idle", {sdo_w[0], oe_w[0]}, 2'b01);

        // R3 single device write
        run_frame(24, pack(1, mk(0, 3'b010, 3'd1, 16'h1234), 0, 0), "chain1");
        chk(dfl[0][31:16] == 16'h1234, "R3 data ch1", dfl[0][31:16], 16'h1234);

        // R5 chain of two and three
        run_frame(48, pack(2, mk(0, 3'b101, 3'd3, 16'h005C), mk(0, 3'b100, 3'd2, 16'h002A), 0), "chain2");
        chk(gfl[1][17:12] == 6'h2A && ofl[0][31:24] == 8'h5C, "R5 chain2 delivery",
            {gfl[1][17:12], ofl[0][31:24]}, {6'h2A, 8'h5C});
        run_frame(72, pack(3, mk(0, 3'b010, 3'd0, 16'hA001), mk(0, 3'b010, 3'd0, 16'hB002),
                           mk(0, 3'b010, 3'd0, 16'hC003)), "chain3");
        chk(dfl[0][15:0] == 16'hA001 && dfl[1][15:0] == 16'hB002 && dfl[2][15:0] == 16'hC003,
            "R5 chain3 delivery", {dfl[0][15:0], dfl[1][15:0], dfl[2][15:0]}, 48'hA001B002C003);

        // R6 readback of fine gain ch0, with R2 stray clocks in between
        run_frame(24, pack(1, mk(0, 3'b100, 3'd0, 16'h0015), 0, 0), "gain0");
        run_frame(24, pack(1, 24'hA0_5A5A, 0, 0), "readreq");
        chk(gfl[0][5:0] == 6'h15 && dfl[0][15:0] == 16'hA001, "R6 read frame writes nothing",
            {gfl[0][5:0], dfl[0][15:0]}, {6'h15, 16'hA001});
        sdin = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk) sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
            repeat (8) @(negedge clk);
        end
        run_frame(24, pack(1, 24'h00_0000, 0, 0), "nop-reply");
        chk(head_reply() == 24'h200015, "R6 reply word", head_reply(), 24'h200015);
        chk(head_reply() == 24'h200015, "R2 stray clocks ignored", head_reply(), 24'h200015);
        run_frame(24, pack(1, 24'h00_0000, 0, 0), "nop-after");
        chk(head_reply() == 24'h0, "R7 reply once", head_reply(), 24'h0);

        // R4 long and short frames
        run_frame(29, (pack(1, mk(0, 3'b010, 3'd2, 16'h7E57), 0, 0) << 5) | 100'h1B, "long29");
        chk(dfl[0][47:32] == 16'h7E57, "R4 last 24 bits kept", dfl[0][47:32], 16'h7E57);
        snap = dfl[0][47:32];
        run_frame(10, 100'h3FF, "short10");
        chk(dfl[0][47:32] == snap, "R4 short frame ignored", dfl[0][47:32], snap);

        // R9 ignored writes
        run_frame(24, pack(1, mk(0, 3'b010, 3'd5, 16'hDEAD), 0, 0), "badchan");
        run_frame(24, pack(1, mk(0, 3'b111, 3'd0, 16'hDEAD), 0, 0), "badkind");
        run_frame(24, pack(1, 24'h50_BEEF, 0, 0), "rsvbit");
        chk(dfl[0][15:0] == 16'hA001 && dfl[0][63:48] == 16'h0, "R9 ignored writes",
            {dfl[0][15:0], dfl[0][63:48]}, {16'hA001, 16'h0});

        // R8 output disable on the head device
        run_frame(24, pack(1, mk(0, 3'b000, 3'd1, 16'h0001), 0, 0), "dis-on");
        chk(oe_w[0] == 1'b0 && sdo_w[0] == 1'b0, "R8 disabled pins", {oe_w[0], sdo_w[0]}, 2'b00);
        run_frame(48, {MAXB{1'b1}} >> (MAXB-48), "ones");
        chk(act_o[0] == '0, "R8 sdo silent", act_o[0][63:0], 64'h0);
        run_frame(24, pack(1, mk(0, 3'b000, 3'd1, 16'h0000), 0, 0), "dis-off");
        chk(oe_w[0] == 1'b1, "R8 re-enabled", oe_w[0], 1'b1);

        // random frames across chain lengths
        for (int t = 0; t < 60; t++) begin
            logic [23:0] w [3];
            int n = 1 + int'($urandom % 3);
            int extra = ($urandom % 4 == 0) ? int'($urandom % 5) : 0;
            for (int d = 0; d < 3; d++) begin
                logic [2:0] kinds [5];
                kinds[0] = 3'b000; kinds[1] = 3'b010; kinds[2] = 3'b100;
                kinds[3] = 3'b101; kinds[4] = 3'b111;
                w[d] = mk($urandom % 4 == 0, kinds[$urandom % 5], 3'($urandom % 6), 16'($urandom));
                if (w[d][21:16] == 6'b000001) w[d][0] = ($urandom % 4 == 0);
            end
            if ($urandom % 10 == 0)
                run_frame(1 + int'($urandom % 23), 100'($urandom), "R4 random short");
            else
                run_frame(24*n + extra, (pack(n, w[0], w[1], w[2]) << extra) | 100'($urandom % 32),
                          "random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule